// File: doc/BRIEF.md
# Per-Link Credit Traffic Policer

This block decides, one frame at a time, whether traffic on a virtual link stays inside its bandwidth contract. Every link owns a credit account kept in a small on-chip table of sixteen entries. Credit flows back into an account in proportion to the time since that account was last updated, at Smax bytes per bandwidth allocation gap (BAG). The account is capped at a ceiling of Smax·(1 + J/BAG), where J is the link's allowed jitter. When a frame arrives, the block tops up its link's account, compares the credit against the frame's cost, and either accepts the frame and charges the account or drops it and leaves the account untouched.

The block sits after frame filtering. The upstream logic presents one frame per cycle: the link index, the MAC frame length L, a flag marking the link's first frame, a free-running microsecond time stamp, and that link's configuration. The configuration gives the BAG as a power-of-two exponent, the jitter in milliseconds, Smax and Smin in line octets, and a mode bit that selects byte-based or frame-based charging. The decision appears one cycle later. When a frame is accepted, the new account value for that link is written back at the same time, in whole bytes. Internally the account is held in thousandths of a byte, so refills that are a fraction of a byte are never lost.

Top module: `vl_policer_top`

## Requirements
- R1: While reset is low and after it is released, `decValid` and `wbValid` stay low until a frame is presented. Every account and every last-update time starts at zero.
- R2: A frame presented with `frmValid` high gives exactly one decision (`decValid` high) on the following cycle. No decision appears in a cycle that follows a cycle without a frame.
- R3: A frame with `frmFirst` high is always accepted, whatever its size or credit. Its account is set to the ceiling minus Smax, and its last-update time is set to `nowUs`.
- R4: The ceiling, in thousandths of a byte, is 1000·Smax + floor(1000·Smax·J / 2^k). Here k is `cfgBagLog2` and J is `cfgJitterMs`.
- R5: Before a non-first frame is judged, its account gains floor(Smax·Δ / 2^k) thousandths of a byte. Δ is (`nowUs` − last-update time) modulo 2^24 µs, saturated at 262143. The refilled account is the smaller of the sum and the ceiling.
- R6: In byte mode (`cfgByteMode` = 1), the cost is 1000·(L + 20). The frame is accepted when the refilled account is at least the cost, and the cost is then subtracted.
- R7: In frame mode (`cfgByteMode` = 0), the cost is 1000·Smax regardless of L, and Smin has no effect.
- R8: A dropped frame produces no write-back and changes neither the account nor the last-update time of its link. The next accepted frame on that link shows this in its refill.
- R9: A non-first frame is dropped when L + 20 exceeds Smax. In byte mode only, it is also dropped when L + 20 is below Smin.
- R10: An accepted frame raises `wbValid` on the decision cycle. `wbLink` then carries the frame's link and `wbBytes` carries floor(new account / 1000).
- R11: A `cfgBagLog2` value k from 0 to 7 selects a BAG of 2^k ms (1 to 128 ms). `cfgJitterMs` takes 0 to 15 ms, which covers the 0 to 10 ms range.
- R12: Links are independent of one another. A frame on the same link in the very next cycle sees the update made by the frame before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frmValid | input | 1 | A filtered frame is presented this cycle |
| frmLink | input | 4 | Virtual link index of the frame |
| frmLen | input | 11 | MAC frame length L in octets |
| frmFirst | input | 1 | First frame ever seen on this link |
| nowUs | input | 24 | Free-running time stamp in microseconds |
| cfgBagLog2 | input | 3 | BAG exponent k, BAG = 2^k ms |
| cfgJitterMs | input | 4 | Maximum jitter J in ms |
| cfgSmax | input | 11 | Largest line size in octets |
| cfgSmin | input | 11 | Smallest line size in octets, used in byte mode |
| cfgByteMode | input | 1 | 1 selects byte-based, 0 frame-based charging |
| decValid | output | 1 | A decision is presented |
| decAccept | output | 1 | 1 accept, 0 drop |
| wbValid | output | 1 | Account write-back strobe |
| wbLink | output | 4 | Link whose account was written |
| wbBytes | output | 17 | New account value in whole bytes |

## Verification
Refill, ceiling clamp and charge all happen in a single cycle. A frame that arrives after a long idle period therefore has its account saturated at the ceiling and charged in the same update. The bench provokes this by advancing the time stamp by tens of milliseconds before sending a frame. It judges the result by requiring the write-back to equal the ceiling minus the cost, not the unclamped sum minus the cost. The first-frame load and the too-long drop also compete in one cycle: an oversized first frame must still be accepted.

// File: rtl/vl_policer_pkg.sv
package vl_policer_pkg;
  // strobes from control to datapath for the account table
  typedef struct packed {
    logic wrFirst;   // load initial credit
    logic wrCharge;  // store refilled credit minus cost
  } polStrobe_t;
endpackage

// File: rtl/vl_policer_datapath.sv
module vl_policer_datapath
  import vl_policer_pkg::*;
#(
  parameter int N_LINKS   = 16,
  parameter int LEN_W     = 11,
  parameter int TIME_W    = 24,
  parameter int BAG_W     = 3,
  parameter int JIT_W     = 4,
  parameter int ACC_W     = 26,
  parameter int ELAPSED_W = 18,
  parameter int SCALE     = 1000,
  parameter int OVERHEAD  = 20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [$clog2(N_LINKS)-1:0] frmLink,
  input  logic [LEN_W-1:0]           frmLen,
  input  logic [TIME_W-1:0]          nowUs,
  input  logic [BAG_W-1:0]           cfgBagLog2,
  input  logic [JIT_W-1:0]           cfgJitterMs,
  input  logic [LEN_W-1:0]           cfgSmax,
  input  logic [LEN_W-1:0]           cfgSmin,
  input  logic                       cfgByteMode,
  input  polStrobe_t                 stb,
  output logic                       creditOk,
  output logic                       tooShort,
  output logic                       tooLong,
  output logic                       wbValid,
  output logic [$clog2(N_LINKS)-1:0] wbLink,
  output logic [ACC_W-10:0]          wbBytes
);
  localparam int LINK_W      = $clog2(N_LINKS);
  localparam int LINE_W      = LEN_W + 1;
  localparam int WIDE_W      = ACC_W + ELAPSED_W;
  localparam int WB_W        = ACC_W - 9;
  localparam int ELAPSED_MAX = (1 << ELAPSED_W) - 1;

  logic [ACC_W-1:0]  accMem  [N_LINKS];
  logic [TIME_W-1:0] lastMem [N_LINKS];

  logic [ACC_W-1:0]     accCur;
  logic [TIME_W-1:0]    lastCur;
  logic [LINE_W-1:0]    lineOct;
  logic [TIME_W-1:0]    elapsed;
  logic [ELAPSED_W-1:0] elapsedSat;
  logic [WIDE_W-1:0]    baseMilli, jitMilli, ceilMilli;
  logic [WIDE_W-1:0]    refillMilli, sumMilli, refilledMilli, costMilli, newAcc;

  assign accCur  = accMem[frmLink];
  assign lastCur = lastMem[frmLink];

  always_comb begin
    lineOct     = LINE_W'(frmLen) + LINE_W'(OVERHEAD);
    baseMilli   = WIDE_W'(cfgSmax) * WIDE_W'(SCALE);
    jitMilli    = (baseMilli * WIDE_W'(cfgJitterMs)) >> cfgBagLog2;
    ceilMilli   = baseMilli + jitMilli;
    elapsed     = nowUs - lastCur;
    elapsedSat  = (elapsed > TIME_W'(ELAPSED_MAX)) ? ELAPSED_W'(ELAPSED_MAX)
                                                   : elapsed[ELAPSED_W-1:0];
    refillMilli = (WIDE_W'(cfgSmax) * WIDE_W'(elapsedSat)) >> cfgBagLog2;
    sumMilli    = WIDE_W'(accCur) + refillMilli;
    refilledMilli = (sumMilli > ceilMilli) ? ceilMilli : sumMilli;
    costMilli   = (cfgByteMode ? WIDE_W'(lineOct) : WIDE_W'(cfgSmax)) * WIDE_W'(SCALE);
    newAcc      = stb.wrFirst ? jitMilli : (refilledMilli - costMilli);
  end

  assign creditOk = refilledMilli >= costMilli;
  assign tooShort = cfgByteMode && (lineOct < LINE_W'(cfgSmin));
  assign tooLong  = lineOct > LINE_W'(cfgSmax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N_LINKS; i++) begin
        accMem[i]  <= '0;
        lastMem[i] <= '0;
      end
    end else if (stb.wrFirst || stb.wrCharge) begin
      accMem[frmLink]  <= ACC_W'(newAcc);
      lastMem[frmLink] <= nowUs;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbLink  <= '0;
      wbBytes <= '0;
    end else begin
      wbValid <= stb.wrFirst || stb.wrCharge;
      wbLink  <= LINK_W'(frmLink);
      wbBytes <= WB_W'(newAcc / WIDE_W'(SCALE));
    end
  end
endmodule

// File: rtl/vl_policer_ctrl.sv
module vl_policer_ctrl
  import vl_policer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frmValid,
  input  logic       frmFirst,
  input  logic       creditOk,
  input  logic       tooShort,
  input  logic       tooLong,
  output polStrobe_t stb,
  output logic       decValid,
  output logic       decAccept
);
  logic conforms;
  logic acceptNow;

  always_comb begin
    conforms     = creditOk && !tooShort && !tooLong;
    acceptNow    = frmFirst || conforms;
    stb.wrFirst  = frmValid && frmFirst;
    stb.wrCharge = frmValid && !frmFirst && conforms;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      decValid  <= frmValid;
      decAccept <= frmValid && acceptNow;
    end
  end
endmodule

// File: rtl/vl_policer_top.sv
module vl_policer_top
  import vl_policer_pkg::*;
#(
  parameter int N_LINKS   = 16,
  parameter int LEN_W     = 11,
  parameter int TIME_W    = 24,
  parameter int BAG_W     = 3,
  parameter int JIT_W     = 4,
  parameter int ACC_W     = 26,
  parameter int ELAPSED_W = 18,
  parameter int SCALE     = 1000,
  parameter int OVERHEAD  = 20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frmValid,
  input  logic [$clog2(N_LINKS)-1:0] frmLink,
  input  logic [LEN_W-1:0]           frmLen,
  input  logic                       frmFirst,
  input  logic [TIME_W-1:0]          nowUs,
  input  logic [BAG_W-1:0]           cfgBagLog2,
  input  logic [JIT_W-1:0]           cfgJitterMs,
  input  logic [LEN_W-1:0]           cfgSmax,
  input  logic [LEN_W-1:0]           cfgSmin,
  input  logic                       cfgByteMode,
  output logic                       decValid,
  output logic                       decAccept,
  output logic                       wbValid,
  output logic [$clog2(N_LINKS)-1:0] wbLink,
  output logic [ACC_W-10:0]          wbBytes
);
  polStrobe_t stb;
  logic creditOk, tooShort, tooLong;

  vl_policer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmFirst(frmFirst),
    .creditOk(creditOk), .tooShort(tooShort), .tooLong(tooLong),
    .stb(stb), .decValid(decValid), .decAccept(decAccept)
  );

  vl_policer_datapath #(
    .N_LINKS(N_LINKS), .LEN_W(LEN_W), .TIME_W(TIME_W), .BAG_W(BAG_W),
    .JIT_W(JIT_W), .ACC_W(ACC_W), .ELAPSED_W(ELAPSED_W), .SCALE(SCALE),
    .OVERHEAD(OVERHEAD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .frmLink(frmLink), .frmLen(frmLen), .nowUs(nowUs),
    .cfgBagLog2(cfgBagLog2), .cfgJitterMs(cfgJitterMs), .cfgSmax(cfgSmax),
    .cfgSmin(cfgSmin), .cfgByteMode(cfgByteMode), .stb(stb),
    .creditOk(creditOk), .tooShort(tooShort), .tooLong(tooLong),
    .wbValid(wbValid), .wbLink(wbLink), .wbBytes(wbBytes)
  );
endmodule

// File: rtl/vl_policer_chk.sv
module vl_policer_chk #(
  parameter int LINK_W = 4,
  parameter int LEN_W  = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              frmValid,
  input logic [LINK_W-1:0] frmLink,
  input logic [LEN_W-1:0]  frmLen,
  input logic              frmFirst,
  input logic [LEN_W-1:0]  cfgSmax,
  input logic              decValid,
  input logic              decAccept,
  input logic              wbValid,
  input logic [LINK_W-1:0] wbLink
);
  logic [LEN_W:0] lineChk;
  assign lineChk = {1'b0, frmLen} + (LEN_W+1)'(20);

  p_decision_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |=> decValid);
  p_no_spurious_decision_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frmValid |=> !decValid);
  p_first_accepted_r3: assert property (@(posedge clk) disable iff (!rstN)
    frmValid && frmFirst |=> decAccept);
  p_drop_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    decValid && !decAccept |-> !wbValid);
  p_oversize_dropped_r9: assert property (@(posedge clk) disable iff (!rstN)
    frmValid && !frmFirst && (lineChk > {1'b0, cfgSmax}) |=> !decAccept);
  p_accept_writes_r10: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |=> (decAccept == wbValid) && (!wbValid || wbLink == $past(frmLink)));
  p_wb_needs_decision_r10: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> decValid);
endmodule

bind vl_policer_top vl_policer_chk #(.LINK_W($clog2(N_LINKS)), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmLink(frmLink),
  .frmLen(frmLen), .frmFirst(frmFirst), .cfgSmax(cfgSmax),
  .decValid(decValid), .decAccept(decAccept), .wbValid(wbValid), .wbLink(wbLink)
);

// File: tb/vl_policer_top_tb.sv
`timescale 1ns/1ps
module vl_policer_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frmValid = 1'b0;
  logic [3:0]  frmLink = '0;
  logic [10:0] frmLen = '0;
  logic        frmFirst = 1'b0;
  logic [23:0] nowUs = '0;
  logic [2:0]  cfgBagLog2 = '0;
  logic [3:0]  cfgJitterMs = '0;
  logic [10:0] cfgSmax = '0;
  logic [10:0] cfgSmin = '0;
  logic        cfgByteMode = 1'b0;
  logic        decValid, decAccept, wbValid;
  logic [3:0]  wbLink;
  logic [16:0] wbBytes;

  always #4 clk = ~clk;

  vl_policer_top u_dut (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmLink(frmLink),
    .frmLen(frmLen), .frmFirst(frmFirst), .nowUs(nowUs),
    .cfgBagLog2(cfgBagLog2), .cfgJitterMs(cfgJitterMs), .cfgSmax(cfgSmax),
    .cfgSmin(cfgSmin), .cfgByteMode(cfgByteMode), .decValid(decValid),
    .decAccept(decAccept), .wbValid(wbValid), .wbLink(wbLink), .wbBytes(wbBytes)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference state and per-link configuration
  longint mAcc[16];
  longint mLast[16];
  int cBag[16], cJit[16], cSmax[16], cSmin[16];
  bit cByte[16];
  longint nowT = 0;
  longint lastWb = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic setCfg(input int l, input int k, input int j, input int smax,
                        input int smin, input bit byteMode);
    cBag[l] = k; cJit[l] = j; cSmax[l] = smax; cSmin[l] = smin; cByte[l] = byteMode;
  endtask

  task automatic advance(input longint us);
    nowT = (nowT + us) % 64'd16777216;
  endtask

  task automatic idle(input string tag);
    frmValid = 1'b0;
    @(negedge clk);
    chk(decValid == 1'b0, tag, "decValid idle", decValid, 0);
    chk(wbValid == 1'b0, tag, "wbValid idle", wbValid, 0);
  endtask

  task automatic frame(input int l, input int len, input bit first, input string tag);
    longint base, jit, ceilv, s, el, refill, sum, filled, cost, newAcc;
    bit acc;
    frmValid = 1'b1; frmLink = 4'(l); frmLen = 11'(len); frmFirst = first;
    nowUs = 24'(nowT);
    cfgBagLog2 = 3'(cBag[l]); cJit2drv(l);
    cfgSmax = 11'(cSmax[l]); cfgSmin = 11'(cSmin[l]); cfgByteMode = cByte[l];
    base = 64'd1000 * cSmax[l];
    jit = (base * cJit[l]) / (64'd1 << cBag[l]);
    ceilv = base + jit;
    s = len + 20;
    if (first) begin
      acc = 1; newAcc = jit;
    end else begin
      el = (nowT - mLast[l]) & 64'hFFFFFF;
      if (el > 262143) el = 262143;
      refill = (cSmax[l] * el) / (64'd1 << cBag[l]);
      sum = mAcc[l] + refill;
      filled = (sum > ceilv) ? ceilv : sum;
      cost = cByte[l] ? 1000 * s : 1000 * cSmax[l];
      acc = (filled >= cost) && !(cByte[l] && s < cSmin[l]) && !(s > cSmax[l]);
      newAcc = filled - cost;
    end
    if (acc) begin
      mAcc[l] = newAcc; mLast[l] = nowT;
    end
    @(negedge clk);
    frmValid = 1'b0;
    chk(decValid == 1'b1, tag, "decValid", decValid, 1);
    chk(decAccept == acc, tag, "decAccept", decAccept, acc);
    chk(wbValid == acc, tag, "wbValid", wbValid, acc);
    if (acc) begin
      chk(wbLink == 4'(l), tag, "wbLink", wbLink, l);
      chk(longint'(wbBytes) == newAcc / 1000, tag, "wbBytes", wbBytes, newAcc / 1000);
      lastWb = wbBytes;
    end
  endtask

  task automatic cJit2drv(input int l);
    cfgJitterMs = 4'(cJit[l]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mAcc[i] = 0; mLast[i] = 0;
      setCfg(i, i % 8, i % 11, 200 + 80 * i, 84, bit'(i % 2));
    end
    setCfg(0, 1, 2, 500, 100, 1);
    setCfg(1, 0, 0, 300, 200, 0);
    setCfg(2, 7, 10, 1538, 84, 1);
    setCfg(3, 3, 5, 800, 300, 1);

    repeat (3) @(negedge clk);
    chk(decValid == 1'b0 && wbValid == 1'b0, "R1", "outputs in reset", decValid, 0);
    rstN = 1'b1;
    idle("R1"); idle("R1"); idle("R2");

    // first frame on link 0: ceiling 1000000, initial 500000
    advance(10);
    frame(0, 100, 1, "R3");
    chk(lastWb == 500, "R4", "initial credit bytes", lastWb, 500);
    frame(0, 100, 0, "R12");   // back to back, byte cost 120000
    chk(lastWb == 380, "R6", "byte charge", lastWb, 380);
    frame(0, 480, 0, "R8");    // cost 500000 > 380000: drop
    advance(200);
    frame(0, 60, 0, "R9");     // below Smin in byte mode
    frame(0, 600, 0, "R9");    // above Smax
    advance(2000);
    frame(0, 480, 0, "R8");    // refill counted from last accept
    idle("R2");
    advance(50000);
    frame(0, 200, 0, "R5");    // clamp and charge together
    chk(lastWb == 780, "R5", "ceiling minus cost", lastWb, 780);

    // frame mode on link 1
    frame(1, 64, 1, "R3");
    frame(1, 64, 0, "R7");
    advance(300);
    frame(1, 64, 0, "R7");
    advance(700);
    frame(1, 64, 0, "R7");     // short frame ignored by Smin in frame mode
    chk(lastWb == 0, "R7", "frame charge is Smax", lastWb, 0);

    // largest BAG and jitter on link 2
    frame(2, 1518, 1, "R11");
    chk(lastWb == 120, "R4", "BAG 128 jitter 10 initial", lastWb, 120);
    frame(2, 1518, 0, "R11");
    advance(200000);
    frame(2, 1518, 0, "R11");
    chk(lastWb == 120, "R11", "BAG 128 full refill", lastWb, 120);

    // untouched link 3 after others were used
    frame(3, 500, 0, "R12");
    frame(2, 2000, 1, "R3");   // oversize first frame still accepted

    // time stamp wrap
    nowT = 16777000;
    frame(0, 100, 0, "R5");
    advance(500);
    frame(0, 100, 0, "R5");

    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      int l;
      l = int'($urandom_range(0, 15));
      advance(longint'($urandom_range(0, 3000)));
      if ($urandom_range(0, 5) == 0) idle("R2");
      frame(l, int'($urandom_range(40, 1530)), ($urandom_range(0, 40) == 0), "R12");
    end
    idle("R2");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule